// File: doc/BRIEF.md
# Disk Controller Idle Sleep Sequencer

This block decides on its own when a disk-controller core may drop into a low-power state, and when the core must come back. While the automatic mode is enabled, it watches four idle indications from the core. These are the motor-enable field of the digital output register, the main status value, the interrupt line and the head-unload timer. When all four have held without a break for a programmable number of microsecond ticks, it raises `core_sleep`. The default count is 10000, which gives 10 ms.

Sleep ends when the host touches one of a small set of registers, or on a hardware or software reset. A wake caused by a register access removes `core_sleep` in the same cycle as the access strobe, so the access can complete against an awake core. A separate direct powerdown request forces `core_sleep` high whatever the automatic state is. When that request is released, the automatic mode takes over again with a fresh idle count.

The sequencer has four named states:
- `ST_OFF`: automatic mode disabled.
- `ST_ARMED`: the idle timer is counting.
- `ST_ASLEEP`: entered through the automatic mode.
- `ST_FORCED`: held by the direct request.

Its transitions are:
- enable (`ST_OFF`→`ST_ARMED`)
- expire (`ST_ARMED`→`ST_ASLEEP`)
- wake (`ST_ASLEEP`→`ST_ARMED`)
- disable (any state except `ST_FORCED`→`ST_OFF`)
- force (any state→`ST_FORCED`)
- release (`ST_FORCED`→`ST_ARMED`, or to `ST_OFF` when the enable is low)
- soft reset (any state→`ST_OFF`)

Priority runs from highest to lowest: soft reset, force, disable, then the state's own transition.

Top module: `fdc_idle_sleep`

## Requirements
- R1: After a hardware reset, `core_sleep` and `timer_run` are 0. Asserting `rst_n` low while asleep clears `core_sleep` at once. After release with `auto_en` high, `timer_run` is 1 after the next edge.
- R2: `timer_run` is 1 exactly while the sequencer is in `ST_ARMED`. Raising `auto_en` sets it one edge later. Clearing `auto_en` drops both outputs at the next edge, and no sleep occurs while `auto_en` stays low.
- R3: With all idle conditions true, `core_sleep` rises at the edge that closes the IDLE_TICKS-th qualifying tick (a cycle with `tick`=1), and not earlier.
- R4: Sleep is prevented while `motor_bits` is non-zero, while `main_status` differs from 8'h80, or while `hut_expired` is 0.
- R5: Sleep is prevented while `intr` is 1, even when `main_status` is 8'h80.
- R6: Any idle condition going false restarts the count, so a full IDLE_TICKS of unbroken idle ticks is needed after it returns.
- R7: While asleep, these accesses wake the core: a write to `acc_sel`=0 (digital output register) with a non-zero `acc_motor`, a read of `acc_sel`=1 (main status), and a read or write of `acc_sel`=2 (data). `core_sleep` is 0 during the strobe cycle itself and stays 0 afterwards.
- R8: A read of `acc_sel`=0, and a write to it with `acc_motor` all zero, leave `core_sleep` at 1.
- R9: After an access wake, sleep needs a full IDLE_TICKS of qualifying ticks again.
- R10: A `soft_rst` pulse while asleep clears `core_sleep` in the same cycle and leaves `timer_run` at 0 after the edge. The next edge re-arms the timer, and a full count follows.
- R11: `direct_pd` sets `core_sleep` at the next edge regardless of `auto_en`, with `timer_run` at 0. While it is held, wake accesses leave `core_sleep` at 1.
- R12: On release of `direct_pd`, the next edge gives `core_sleep`=0. `timer_run` is 1 if `auto_en` is high, followed by a full idle count, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| tick | input | 1 | One-cycle clock enable every microsecond |
| auto_en | input | 1 | Automatic powerdown enable |
| soft_rst | input | 1 | Software reset pulse from the core's reset bits |
| direct_pd | input | 1 | Direct powerdown request (level) |
| motor_bits | input | MOTORS | Current motor-enable field of the digital output register |
| main_status | input | 8 | Current main status value |
| intr | input | 1 | Controller interrupt output |
| hut_expired | input | 1 | Head-unload timer has expired |
| acc_valid | input | 1 | Register access strobe, one cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | 0 digital output, 1 main status, 2 data, 3 other |
| acc_motor | input | MOTORS | Motor-enable field of the write data |
| core_sleep | output | 1 | Core powerdown |
| timer_run | output | 1 | Idle timer armed |

## Verification
If the idle counter keeps a stale value, `core_sleep` rises a few ticks early, and the bench catches this within one idle window after any condition break or wake. If the state register is left in the wrong state, the mistake shows either at the very next edge or in the strobe cycle. A wake or soft reset that fails to reach the state leaves `core_sleep` high in the strobe cycle. A missed force leaves `timer_run` high after the force edge. A wrong state on release shows as an immediate sleep instead of a full count.

// File: rtl/idle_sleep_pkg.sv
`timescale 1ns/1ps
package idle_sleep_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_ARMED  = 2'd1,
        ST_ASLEEP = 2'd2,
        ST_FORCED = 2'd3
    } sleep_state_t;

    localparam logic [7:0] STATUS_READY = 8'h80;

    localparam logic [1:0] SEL_DOUT   = 2'd0;
    localparam logic [1:0] SEL_STATUS = 2'd1;
    localparam logic [1:0] SEL_DATA   = 2'd2;
endpackage

// File: rtl/idle_qualifier.sv
`timescale 1ns/1ps
module idle_qualifier
    import idle_sleep_pkg::*;
#(
    parameter int MOTORS = 4
) (
    input  logic [MOTORS-1:0] motor_bits,
    input  logic [7:0]        main_status,
    input  logic              intr,
    input  logic              hut_expired,
    output logic              idle_ok
);
    logic motors_off;
    logic ctrl_ready;

    assign motors_off = (motor_bits == '0);
    // A polled interrupt may be pending with status showing ready.
    assign ctrl_ready = (main_status == STATUS_READY) && !intr;
    assign idle_ok    = motors_off && ctrl_ready && hut_expired;
endmodule

// File: rtl/wake_decoder.sv
`timescale 1ns/1ps
module wake_decoder
    import idle_sleep_pkg::*;
#(
    parameter int MOTORS = 4
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_sel,
    input  logic [MOTORS-1:0] acc_motor,
    output logic              wake_hit
);
    logic dout_spin;
    logic status_rd;
    logic data_any;

    assign dout_spin = acc_write && (acc_sel == SEL_DOUT) && (acc_motor != '0);
    assign status_rd = !acc_write && (acc_sel == SEL_STATUS);
    assign data_any  = (acc_sel == SEL_DATA);
    assign wake_hit  = acc_valid && (dout_spin || status_rd || data_any);
endmodule

// File: rtl/idle_timer.sv
`timescale 1ns/1ps
module idle_timer #(
    parameter int IDLE_TICKS = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(IDLE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_TICKS - 1);

    logic [CW-1:0] count_q;

    assign expired = run && tick && (count_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear || expired) begin
            count_q <= '0;
        end else if (run && tick) begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/fdc_idle_sleep.sv
`timescale 1ns/1ps
module fdc_idle_sleep
    import idle_sleep_pkg::*;
#(
    parameter int MOTORS     = 4,
    parameter int IDLE_TICKS = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              auto_en,
    input  logic              soft_rst,
    input  logic              direct_pd,
    input  logic [MOTORS-1:0] motor_bits,
    input  logic [7:0]        main_status,
    input  logic              intr,
    input  logic              hut_expired,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_sel,
    input  logic [MOTORS-1:0] acc_motor,
    output logic              core_sleep,
    output logic              timer_run
);
    sleep_state_t state_q, state_d;
    logic idle_ok, wake_hit, expired;
    logic tmr_run, tmr_clear;
    logic sleep_q, run_q;

    idle_qualifier #(.MOTORS(MOTORS)) u_qual (
        .motor_bits (motor_bits),
        .main_status(main_status),
        .intr       (intr),
        .hut_expired(hut_expired),
        .idle_ok    (idle_ok)
    );

    wake_decoder #(.MOTORS(MOTORS)) u_wake (
        .acc_valid(acc_valid),
        .acc_write(acc_write),
        .acc_sel  (acc_sel),
        .acc_motor(acc_motor),
        .wake_hit (wake_hit)
    );

    // Counts only unbroken idle time in ST_ARMED; any break reloads.
    assign tmr_run   = (state_q == ST_ARMED) && idle_ok && !wake_hit;
    assign tmr_clear = !tmr_run;

    idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tmr_clear),
        .run    (tmr_run),
        .tick   (tick),
        .expired(expired)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    if (auto_en)    state_d = ST_ARMED;
            ST_ARMED:  if (expired)    state_d = ST_ASLEEP;
            ST_ASLEEP: if (wake_hit)   state_d = ST_ARMED;
            ST_FORCED: if (!direct_pd) state_d = auto_en ? ST_ARMED : ST_OFF;
            default:                   state_d = ST_OFF;
        endcase
        if (!auto_en && state_q != ST_FORCED) state_d = ST_OFF;
        if (direct_pd)                        state_d = ST_FORCED;
        if (soft_rst)                         state_d = ST_OFF;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sleep_q <= 1'b0;
            run_q   <= 1'b0;
        end else begin
            sleep_q <= (state_d == ST_ASLEEP) || (state_d == ST_FORCED);
            run_q   <= (state_d == ST_ARMED);
        end
    end

    // A wake access lifts sleep in its own cycle so it can complete.
    assign core_sleep = sleep_q &&
        !((state_q == ST_ASLEEP) && (wake_hit || soft_rst));
    assign timer_run  = run_q;
endmodule

// File: rtl/idle_sleep_checker.sv
`timescale 1ns/1ps
module idle_sleep_checker #(
    parameter int MOTORS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              auto_en,
    input logic              soft_rst,
    input logic              direct_pd,
    input logic [MOTORS-1:0] motor_bits,
    input logic [7:0]        main_status,
    input logic              intr,
    input logic              hut_expired,
    input logic              acc_valid,
    input logic [1:0]        acc_sel,
    input logic              core_sleep,
    input logic              timer_run
);
    assert_armed_awake_R2: assert property (@(posedge clk) disable iff (!rst_n)
        timer_run |-> !core_sleep);

    assert_disable_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && !direct_pd) |=> !timer_run);

    assert_idle_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_sleep) && !$past(direct_pd)) |->
            $past(motor_bits == '0 && main_status == 8'h80 && hut_expired));

    assert_intr_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_sleep) && !$past(direct_pd)) |-> !$past(intr));

    assert_data_wakes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_sel == 2'd2 && !$past(direct_pd)) |-> !core_sleep);

    assert_soft_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!core_sleep && !timer_run));

    assert_force_sleeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_pd && !soft_rst) |=> (core_sleep && !timer_run));
endmodule

bind fdc_idle_sleep idle_sleep_checker #(.MOTORS(MOTORS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_en    (auto_en),
    .soft_rst   (soft_rst),
    .direct_pd  (direct_pd),
    .motor_bits (motor_bits),
    .main_status(main_status),
    .intr       (intr),
    .hut_expired(hut_expired),
    .acc_valid  (acc_valid),
    .acc_sel    (acc_sel),
    .core_sleep (core_sleep),
    .timer_run  (timer_run)
);

// File: tb/fdc_idle_sleep_test.sv
`timescale 1ns/1ps
module fdc_idle_sleep_test;
    localparam int MOTORS = 4;
    localparam int N      = 8;

    typedef struct {
        int    s;
        int    r;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, auto_en = 1'b0, soft_rst = 1'b0, direct_pd = 1'b0;
    logic [MOTORS-1:0] motor_bits = '0;
    logic [7:0] main_status = 8'h80;
    logic intr = 1'b0, hut_expired = 1'b1;
    logic acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0] acc_sel = 2'd3;
    logic [MOTORS-1:0] acc_motor = '0;
    logic core_sleep, timer_run;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    exp_t pre_q[$];
    exp_t post_q[$];

    always #2.5 clk = ~clk;

    fdc_idle_sleep #(.MOTORS(MOTORS), .IDLE_TICKS(N)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .auto_en(auto_en),
        .soft_rst(soft_rst), .direct_pd(direct_pd), .motor_bits(motor_bits),
        .main_status(main_status), .intr(intr), .hut_expired(hut_expired),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel),
        .acc_motor(acc_motor), .core_sleep(core_sleep), .timer_run(timer_run)
    );

    function automatic void compare(exp_t e);
        checks++;
        if (int'(core_sleep) != e.s) begin
            errors++;
            $display("FAIL %s: core_sleep=%0d expected %0d", e.tag, core_sleep, e.s);
        end
        if (e.r >= 0) begin
            checks++;
            if (int'(timer_run) != e.r) begin
                errors++;
                $display("FAIL %s: timer_run=%0d expected %0d", e.tag, timer_run, e.r);
            end
        end
    endfunction

    // Monitor: pre items just before the coming edge, post items just after it.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (pre_q.size() > 0) compare(pre_q.pop_front());
            @(posedge clk);
            #1;
            while (post_q.size() > 0) compare(post_q.pop_front());
        end
    end

    task automatic exp_pre(input int s, input string tag);
        exp_t e;
        e.s = s; e.r = -1; e.tag = tag;
        pre_q.push_back(e);
    endtask

    task automatic exp_post(input int s, input int r, input string tag);
        exp_t e;
        e.s = s; e.r = r; e.tag = tag;
        post_q.push_back(e);
    endtask

    // Driver: one cycle of stimulus, strobes last exactly this cycle.
    task automatic go(input bit tk, input bit v, input bit w,
                      input logic [1:0] sel, input logic [MOTORS-1:0] mot, input bit sr);
        @(negedge clk);
        tick = tk; acc_valid = v; acc_write = w; acc_sel = sel;
        acc_motor = mot; soft_rst = sr;
    endtask

    task automatic idle1(input bit tk);
        go(tk, 1'b0, 1'b0, 2'd3, '0, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) idle1(1'b1);
    endtask

    // Timer is armed with a zero count: N-1 ticks stay awake, the N-th sleeps.
    task automatic full_count(input string tag);
        ticks(N - 1);
        exp_post(0, 1, tag);
        idle1(1'b1);
        exp_post(1, 0, tag);
    endtask

    task automatic set_cond(input int c, input bit busy);
        case (c)
            0: motor_bits = busy ? 4'b0100 : 4'b0000;
            1: main_status = busy ? 8'h90 : 8'h80;
            2: intr = busy;
            default: hut_expired = !busy;
        endcase
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        idle1(0); rst_n = 1'b1;
        exp_post(0, 0, "R1 reset state");

        idle1(0); auto_en = 1'b1;
        exp_post(0, 1, "R2 enable arms timer");
        full_count("R3 sleep after idle window");

        // R8: read of output register, zero-motor write: stay asleep
        go(0, 1, 0, 2'd0, '0, 0);
        exp_pre(1, "R8 dout read same cycle");
        exp_post(1, 0, "R8 dout read");
        go(0, 1, 1, 2'd0, '0, 0);
        exp_pre(1, "R8 dout zero write same cycle");
        exp_post(1, 0, "R8 dout zero write");

        // R7 wakes, each followed by a full R9 count
        go(0, 1, 1, 2'd0, 4'b0010, 0);
        exp_pre(0, "R7 motor write same cycle");
        exp_post(0, 1, "R7 motor write");
        full_count("R9 recount after motor write");

        go(0, 1, 0, 2'd1, '0, 0);
        exp_pre(0, "R7 status read same cycle");
        exp_post(0, 1, "R7 status read");
        full_count("R9 recount after status read");

        go(0, 1, 0, 2'd2, '0, 0);
        exp_pre(0, "R7 data read same cycle");
        exp_post(0, 1, "R7 data read");
        full_count("R9 recount after data read");

        go(0, 1, 1, 2'd2, '0, 0);
        exp_pre(0, "R7 data write same cycle");
        exp_post(0, 1, "R7 data write");
        full_count("R9 recount after data write");

        // R4/R5 each condition alone blocks; R6 reload on return
        for (int c = 0; c < 4; c++) begin
            go(0, 1, 0, 2'd2, '0, 0);
            exp_post(0, 1, "R7 wake before condition test");
            ticks(N - 2);
            idle1(0); set_cond(c, 1'b1);
            ticks(2 * N);
            exp_post(0, 1, (c == 2) ? "R5 interrupt blocks sleep" : "R4 busy condition blocks sleep");
            idle1(0); set_cond(c, 1'b0);
            full_count("R6 full recount after condition break");
        end

        // R10 soft reset while asleep
        go(0, 0, 0, 2'd3, '0, 1);
        exp_pre(0, "R10 soft reset same cycle");
        exp_post(0, 0, "R10 soft reset state");
        idle1(0);
        exp_post(0, 1, "R10 rearm after soft reset");
        full_count("R10 full count after soft reset");

        // R11/R12 direct powerdown mid-count with auto enabled
        go(0, 1, 0, 2'd2, '0, 0);
        ticks(3);
        idle1(0); direct_pd = 1'b1;
        exp_post(1, 0, "R11 direct forces sleep");
        go(0, 1, 0, 2'd1, '0, 0);
        exp_pre(1, "R11 access ignored while forced");
        exp_post(1, 0, "R11 still forced");
        idle1(0); direct_pd = 1'b0;
        exp_post(0, 1, "R12 release rearms");
        full_count("R12 full count after release");

        // R2 disable while asleep, then no sleep
        idle1(0); auto_en = 1'b0;
        exp_post(0, 0, "R2 disable clears");
        ticks(2 * N);
        exp_post(0, 0, "R2 no sleep while disabled");

        // R11/R12 direct with auto disabled
        idle1(0); direct_pd = 1'b1;
        exp_post(1, 0, "R11 direct with auto off");
        idle1(0); direct_pd = 1'b0;
        exp_post(0, 0, "R12 release with auto off");

        idle1(0); auto_en = 1'b1;
        exp_post(0, 1, "R2 re-enable arms");
        full_count("R3 sleep after re-enable");

        // R1 hardware reset while asleep
        idle1(0); rst_n = 1'b0;
        exp_pre(0, "R1 hardware reset clears sleep");
        exp_post(0, 0, "R1 reset held");
        idle1(0); rst_n = 1'b1;
        exp_post(0, 1, "R1 rearm after reset");

        idle1(0);
        idle1(0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule